// File: doc/BRIEF.md
# Embedded Chip Erase Sequencer

This block runs a complete chip erase without host help once the command decoder has seen the final write strobe of the erase command and raised a one-cycle start. It drives a simple array port. First it programs every location to all zeros and reads each one back. A location that does not read zero sends the sequencer back for another program pass. After the array reads all zeros, it issues whole-array erase pulses. After each pulse it re-reads the array until every location reads all ones.

The number of program passes and erase pulses is bounded by a parameter. When that bound runs out, the block enters a failed state and stays there until the host issues a reset command. While the block is running or failed, it presents a polling status byte. Bit 7 is a completion flag, bit 6 toggles on each status read, and bit 5 flags a timeout. On success the block returns to idle, which corresponds to array-read mode.

Top module: `erase_seq`

## Requirements
- R1: A one-cycle `start_i` in idle makes `busy_o` high from the next clock edge, with no host input needed until completion.
- R2: Every address from 0 to DEPTH-1 receives a program strobe (`arr_prog_o`) before the first erase strobe (`arr_erase_o`) of a run.
- R3: After the zero check passes, erase strobes repeat, each followed by a read-back pass, until every location reads FFh. The number of erase strobes equals the fewest pulses after which the whole array reads FFh.
- R4: Status bit 7 reads 0 while busy or failed and reads 1 in idle.
- R5: Status bit 6 inverts after each `status_rd_i` cycle while busy or failed, and holds its value through status reads in idle.
- R6: If the array still fails the FFh check after MAX_PULSES erase strobes, the block fails: `fail_o`=1, status bit 5=1, `busy_o`=0, and no further strobes are issued.
- R7: In the failed state, `start_i` is ignored and no program or erase strobes are issued until `reset_cmd_i`.
- R8: `reset_cmd_i` in the failed state returns the block to idle, with `fail_o`=0, status bit 5=0 and status bit 7=1.
- R9: A successful run ends with exactly one single-cycle `done_o` pulse, and every location then reads FFh.
- R10: `start_i` and `reset_cmd_i` asserted while busy have no effect: the run continues and its strobe counts are unchanged.
- R11: If a location never reads 00h, the block fails after MAX_PULSES program passes of DEPTH strobes each, with zero erase strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start from the command decoder |
| reset_cmd_i | input | 1 | Reset command; leaves the failed state |
| status_rd_i | input | 1 | One cycle per host status read |
| arr_rdata_i | input | DW | Array read-back data at `arr_addr_o`, same cycle |
| arr_addr_o | output | clog2(DEPTH) | Array location address |
| arr_prog_o | output | 1 | Program the addressed location to zero |
| arr_erase_o | output | 1 | One whole-array erase pulse |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse on success |
| fail_o | output | 1 | Timed-out state |
| stat_o | output | 8 | Polling status: bit 7 complete, bit 6 toggle, bit 5 timeout |

## Verification
The hardest case to reach is a run that needs exactly MAX_PULSES erase pulses, or one more, because the bound is decided by the slowest single cell. The bench array model gives each cell its own pulse requirement. Directed cases place one slow cell at the limit and just past it, and random cases draw the requirements around the limit. A stuck cell that never programs to zero drives the separate program-phase timeout.

// File: rtl/esq_pkg.sv
// Package: shared state encoding and status-byte bit positions for the
// chip erase sequencer. Assumes an 8-bit polling status byte.
package esq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_PVER  = 3'd2,
        ST_ERASE = 3'd3,
        ST_EVER  = 3'd4,
        ST_FAIL  = 3'd5
    } esq_state_t;

    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_TOG_BIT  = 6;
    localparam int STAT_TMO_BIT  = 5;
endpackage

// File: rtl/esq_addr_ctr.sv
// Address walker: steps through locations 0..DEPTH-1 for one pass.
// Assumes clear has priority over increment and DEPTH >= 2.
module esq_addr_ctr #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     inc_i,
    output logic [$clog2(DEPTH)-1:0] addr_o,
    output logic                     last_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Holds the current pass position; rewinds on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) addr_o <= '0;
        else if (inc_i)      addr_o <= addr_o + 1'b1;
    end

    assign last_o = (addr_o == LAST);

    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && last_o) |=> (addr_o == '0) || (addr_o == LAST))
        else $error("address walked past the last location");
endmodule

// File: rtl/esq_try_ctr.sv
// Attempt counter shared by program passes and erase pulses.
// Assumes the controller never increments once the limit is reached.
module esq_try_ctr #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic spent_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Counts attempts in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (inc_i)      cnt_q <= cnt_q + 1'b1;
    end

    assign spent_o = (cnt_q == LIM);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spent_o |-> !(inc_i && !clr_i))
        else $error("attempt counter incremented past its limit");
endmodule

// File: rtl/esq_status.sv
// Polling status byte: completion flag, read toggle and timeout flag.
// Assumes one status_rd_i cycle per host status read.
module esq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       fail_i,
    input  logic       rd_i,
    output logic [7:0] stat_o
);
    import esq_pkg::*;

    logic tog_q;

    // Inverts the toggle bit on each status read while not idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        tog_q <= 1'b0;
        else if (rd_i && (run_i || fail_i)) tog_q <= ~tog_q;
    end

    // Assembles the status byte.
    always_comb begin
        stat_o                = '0;
        stat_o[STAT_DONE_BIT] = ~(run_i | fail_i);
        stat_o[STAT_TOG_BIT]  = tog_q;
        stat_o[STAT_TMO_BIT]  = fail_i;
    end
endmodule

// File: rtl/erase_seq.sv
// Chip erase sequencer top: pre-programs all locations to zero with
// verify, then repeats erase pulse plus verify until all read erased,
// bounded by MAX_PULSES. Assumes combinational array read-back at
// arr_addr_o and one-cycle program/erase strobes.
module erase_seq #(
    parameter int DEPTH      = 16,
    parameter int DW         = 8,
    parameter int MAX_PULSES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     reset_cmd_i,
    input  logic                     status_rd_i,
    input  logic [DW-1:0]            arr_rdata_i,
    output logic [$clog2(DEPTH)-1:0] arr_addr_o,
    output logic                     arr_prog_o,
    output logic                     arr_erase_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     fail_o,
    output logic [7:0]               stat_o
);
    import esq_pkg::*;

    localparam logic [DW-1:0] ERASED = '1;
    localparam logic [DW-1:0] ZEROED = '0;

    esq_state_t state_q, state_d;
    logic addr_clr, addr_inc, last;
    logic try_clr, try_inc, spent;
    logic done_q;

    esq_addr_ctr #(.DEPTH(DEPTH)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr_i(addr_clr), .inc_i(addr_inc),
        .addr_o(arr_addr_o), .last_o(last)
    );

    esq_try_ctr #(.LIMIT(MAX_PULSES)) u_try (
        .clk(clk), .rst_n(rst_n), .clr_i(try_clr), .inc_i(try_inc),
        .spent_o(spent)
    );

    // Sequencing decisions and array strobes for the current state.
    always_comb begin
        state_d     = state_q;
        addr_clr    = 1'b0;
        addr_inc    = 1'b0;
        try_clr     = 1'b0;
        try_inc     = 1'b0;
        arr_prog_o  = 1'b0;
        arr_erase_o = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                addr_clr = 1'b1;
                try_clr  = 1'b1;
                state_d  = ST_PROG;
            end
            ST_PROG: begin
                arr_prog_o = 1'b1;
                if (last) begin
                    addr_clr = 1'b1;
                    try_inc  = 1'b1;
                    state_d  = ST_PVER;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_PVER: begin
                if (arr_rdata_i != ZEROED) begin
                    addr_clr = 1'b1;
                    state_d  = spent ? ST_FAIL : ST_PROG;
                end else if (last) begin
                    addr_clr = 1'b1;
                    try_clr  = 1'b1;
                    state_d  = ST_ERASE;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_ERASE: begin
                arr_erase_o = 1'b1;
                try_inc     = 1'b1;
                state_d     = ST_EVER;
            end
            ST_EVER: begin
                if (arr_rdata_i != ERASED) begin
                    addr_clr = 1'b1;
                    state_d  = spent ? ST_FAIL : ST_ERASE;
                end else if (last) begin
                    addr_clr = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_FAIL: if (reset_cmd_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the one-cycle success pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_EVER) && (state_d == ST_IDLE);
        end
    end

    assign busy_o = (state_q != ST_IDLE) && (state_q != ST_FAIL);
    assign fail_o = (state_q == ST_FAIL);
    assign done_o = done_q;

    esq_status u_stat (
        .clk(clk), .rst_n(rst_n), .run_i(busy_o), .fail_i(fail_o),
        .rd_i(status_rd_i), .stat_o(stat_o)
    );

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog_o && arr_erase_o))
        else $error("program and erase strobes together");

    p_quiet_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !arr_prog_o && !arr_erase_o)
        else $error("array strobe while not busy");

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !reset_cmd_i) |=> fail_o)
        else $error("failed state left without reset command");

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o)
        else $error("done pulse longer than one cycle");

    p_tog_frozen_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !fail_o) |=> $stable(stat_o[STAT_TOG_BIT]))
        else $error("toggle bit moved in idle");

    p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !stat_o[STAT_DONE_BIT])
        else $error("completion flag set while busy");
endmodule

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
    localparam int DEPTH = 16;
    localparam int MAXP  = 6;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, reset_cmd_i = 1'b0, status_rd_i = 1'b0;
    logic [7:0] arr_rdata;
    logic [AW-1:0] arr_addr;
    logic arr_prog, arr_erase, busy, done, fail;
    logic [7:0] stat;

    int checks = 0, errors = 0;
    int cycles = 0;

    // Behavioural array model.
    logic [7:0] mem [DEPTH];
    logic [7:0] pre_mem [DEPTH];
    logic [7:0] stuck [DEPTH];
    int need [DEPTH];
    bit progd [DEPTH];
    int epulses, ppulses, dones;
    bit early_erase;
    bit load = 1'b0;

    always #4 clk = ~clk;

    erase_seq #(.DEPTH(DEPTH), .DW(8), .MAX_PULSES(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reset_cmd_i(reset_cmd_i),
        .status_rd_i(status_rd_i), .arr_rdata_i(arr_rdata), .arr_addr_o(arr_addr),
        .arr_prog_o(arr_prog), .arr_erase_o(arr_erase), .busy_o(busy),
        .done_o(done), .fail_o(fail), .stat_o(stat)
    );

    assign arr_rdata = mem[arr_addr];

    always @(posedge clk) begin
        if (load) begin
            epulses <= 0; ppulses <= 0; dones <= 0; early_erase <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= pre_mem[i];
                progd[i] <= 1'b0;
            end
        end else begin
            if (arr_prog) begin
                mem[arr_addr] <= stuck[arr_addr];
                progd[arr_addr] <= 1'b1;
                ppulses <= ppulses + 1;
            end
            if (arr_erase) begin
                epulses <= epulses + 1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (epulses + 1 >= need[i]) mem[i] <= 8'hFF;
                    if (!progd[i]) early_erase <= 1'b1;
                end
            end
            if (done) dones <= dones + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1; tick(1); start_i = 1'b0;
    endtask

    task automatic status_read(output logic [7:0] v_before, output logic [7:0] v_after);
        v_before = stat;
        status_rd_i = 1'b1; tick(1); status_rd_i = 1'b0;
        v_after = stat;
    endtask

    function automatic int max_need();
        int m = 0;
        for (int i = 0; i < DEPTH; i++) if (need[i] > m) m = need[i];
        return m;
    endfunction

    function automatic bit any_stuck();
        for (int i = 0; i < DEPTH; i++) if (stuck[i] != 8'h00) return 1'b1;
        return 1'b0;
    endfunction

    task automatic prepare();
        for (int i = 0; i < DEPTH; i++) pre_mem[i] = 8'($urandom);
        load = 1'b1; tick(1); load = 1'b0;
    endtask

    // Runs one erase and checks the outcome against the model's expectation.
    task automatic run_case(input string name, input bit poke);
        logic [7:0] a, b;
        int mn;
        bit exp_fail;
        prepare();
        mn = max_need();
        exp_fail = any_stuck() || (mn > MAXP);
        pulse_start();
        chk(busy === 1'b1, "R1 busy after start", busy, 1);
        if (poke) begin
            tick(1);
            status_read(a, b);
            chk(b[6] === ~a[6], "R5 toggle while busy", b[6], ~a[6]);
            chk(a[7] === 1'b0, "R4 bit7 low while busy", a[7], 0);
            status_read(a, b);
            chk(b[6] === ~a[6], "R5 second toggle", b[6], ~a[6]);
            start_i = 1'b1; reset_cmd_i = 1'b1; tick(1);
            start_i = 1'b0; reset_cmd_i = 1'b0;
            chk(busy === 1'b1, "R10 busy kept after stray commands", busy, 1);
        end
        for (int i = 0; i < 5000 && busy; i++) tick(1);
        tick(1);
        if (any_stuck()) begin
            chk(fail === 1'b1, {"R11 fail ", name}, fail, 1);
            chk(epulses == 0, {"R11 no erase ", name}, epulses, 0);
            chk(ppulses == MAXP * DEPTH, {"R11 program strobes ", name}, ppulses, MAXP * DEPTH);
        end else if (exp_fail) begin
            chk(fail === 1'b1, {"R6 fail ", name}, fail, 1);
            chk(stat[5] === 1'b1 && stat[7] === 1'b0, {"R6 status ", name}, stat, 8'h20);
            chk(epulses == MAXP, {"R6 pulses ", name}, epulses, MAXP);
        end else begin
            chk(fail === 1'b0 && busy === 1'b0, {"R9 finished ", name}, fail, 0);
            chk(epulses == mn, {"R3 pulses ", name}, epulses, mn);
            chk(dones == 1, {"R9 done count ", name}, dones, 1);
            chk(!early_erase, {"R2 preprogram order ", name}, early_erase, 0);
            for (int i = 0; i < DEPTH; i++)
                chk(mem[i] == 8'hFF, {"R9 erased ", name}, mem[i], 8'hFF);
            chk(stat[7] === 1'b1 && stat[5] === 1'b0, {"R4 idle status ", name}, stat[7], 1);
        end
        if (fail) begin
            pulse_start();
            tick(3);
            chk(fail === 1'b1 && ppulses == (any_stuck() ? MAXP * DEPTH : ppulses),
                "R7 start ignored in fail", fail, 1);
            chk(busy === 1'b0, "R7 stays stopped", busy, 0);
            status_read(a, b);
            chk(b[6] === ~a[6], "R5 toggle while failed", b[6], ~a[6]);
            reset_cmd_i = 1'b1; tick(1); reset_cmd_i = 1'b0;
            chk(fail === 1'b0 && stat[5] === 1'b0 && stat[7] === 1'b1,
                "R8 reset leaves fail", stat, 8'h80);
        end
        for (int i = 0; i < DEPTH; i++) stuck[i] = 8'h00;
    endtask

    initial begin
        logic [7:0] a, b;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin
            need[i] = 1; stuck[i] = 8'h00; pre_mem[i] = 8'h5A;
        end
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk(busy === 1'b0 && fail === 1'b0 && done === 1'b0, "R1 reset idle", busy, 0);
        chk(stat[7] === 1'b1 && stat[5] === 1'b0, "R4 reset status", stat, 8'h80);
        chk(arr_prog === 1'b0 && arr_erase === 1'b0, "R2 no strobes at reset", arr_prog, 0);
        status_read(a, b);
        chk(b[6] === a[6], "R5 toggle frozen in idle", b[6], a[6]);

        run_case("single pulse", 1'b1);
        for (int i = 0; i < DEPTH; i++) need[i] = 2;
        need[DEPTH-1] = MAXP;
        run_case("at limit", 1'b0);
        need[3] = MAXP + 1;
        run_case("past limit", 1'b0);
        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        stuck[5] = 8'h10;
        run_case("stuck cell", 1'b0);
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < DEPTH; i++) need[i] = 1 + int'($urandom % (MAXP + (r % 2)));
            run_case("random", r == 2);
        end
        status_read(a, b);
        chk(b[6] === a[6], "R5 toggle frozen after runs", b[6], a[6]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule